// File: doc/BRIEF.md
# RAM-Backed Programmable Delay Line

This block delays a stream of data words by a run-time selectable number of active cycles, from zero up to sixty-three. The samples are never shifted. Each word is written once into a small register-array RAM and stays at that address. A write address and a read address move forward together, and the distance between them picks which stored word reaches the output. A large delay therefore costs RAM entries and one adder, not a chain of flip-flops switching on every cycle.

An enable input marks the active cycles. While enable is low, the line is frozen: the pointers stand still, the RAM is not written, and the output keeps the word and the valid flag it showed on the last active cycle. A valid flag stays low until enough samples have entered the line since reset to fill the selected delay. A delay of zero forwards the input to the output in the same cycle.

Top module: `dly_line_ram`

## Requirements
- R1: After reset, the read pointer is at entry 0, the write pointer is at entry 63, and the fill count is zero. While enable stays low after reset, `dout` reads 0 and `out_valid` reads 0.
- R2: On every active cycle (`en` = 1), the input word is written at the write pointer and both pointers advance by one, modulo 64. On a cycle with `en` = 0, neither pointer moves and no entry is written. A stream that resumes after such a gap continues exactly where it stopped.
- R3: With a delay of N between 1 and 63, `dout` on an active cycle equals the `din` presented on the active cycle N active cycles earlier.
- R4: With a delay of 0, `dout` equals `din` in the same cycle and `out_valid` is 1.
- R5: The `delay` input is registered on every clock edge, with or without enable. A new setting therefore governs the output from the cycle after it is presented.
- R6: On an active cycle, `out_valid` is 1 exactly when the number of active cycles since reset is at least the registered delay. The count saturates at 63.
- R7: While `en` is low, `dout` and `out_valid` hold the values they had on the last active cycle. They hold 0 and 0 if no active cycle has occurred since reset.
- R8: The pointers wrap modulo the 64-entry depth. The delay stays exact over runs far longer than 64 samples, including at the largest delay of 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Marks an active cycle; low freezes the line |
| din | input | DATA_W (8) | Input data word |
| delay | input | ADDR_W (6) | Delay in active cycles, 0 to 63 |
| dout | output | DATA_W (8) | Delayed data word |
| out_valid | output | 1 | High when `dout` carries a real sample |

## Verification
The bench builds the block with its default parameters: 8-bit words and 6 address bits, which give a 64-entry RAM and the full 0 to 63 delay range. With only 64 entries, a run of a few thousand cycles wraps the pointers dozens of times. The maximum delay of 63 and the zero-delay bypass are both reachable directly. Random enable gaps and random changes of the delay exercise the freeze behaviour, the one-cycle latency of a new setting, and the change of the valid flag when the delay rises above the fill count.

// File: rtl/dly_pkg.sv
package dly_pkg;
    // Default geometry of the delay line
    localparam int DEF_DATA_W = 8;
    localparam int DEF_ADDR_W = 6;
endpackage

// File: rtl/dly_ptr_ctrl.sv
module dly_ptr_ctrl #(
    parameter int ADDR_W = dly_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] delay_in,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] delay_q,
    output logic [ADDR_W-1:0] fill,
    output logic              fill_ok
);
    localparam logic [ADDR_W-1:0] TOP_IDX = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
        logic [ADDR_W-1:0] dly;
        logic [ADDR_W-1:0] fill;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.dly = delay_in;
        if (en) begin
            st_d.wr = st_q.wr + 1'b1;
            st_d.rd = st_q.rd + 1'b1;
            if (st_q.fill != TOP_IDX) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr   <= TOP_IDX;
            st_q.rd   <= '0;
            st_q.dly  <= '0;
            st_q.fill <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // rd tracks the oldest entry; a shorter delay moves the tap toward wr
    assign rd_addr = st_q.rd + (TOP_IDX - st_q.dly);
    assign wr_ptr  = st_q.wr;
    assign rd_ptr  = st_q.rd;
    assign delay_q = st_q.dly;
    assign fill    = st_q.fill;
    assign fill_ok = (st_q.fill >= st_q.dly);
endmodule

// File: rtl/dly_ram.sv
module dly_ram #(
    parameter int DATA_W = dly_pkg::DEF_DATA_W,
    parameter int ADDR_W = dly_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dly_out_hold.sv
module dly_out_hold #(
    parameter int DATA_W = dly_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] live_data,
    input  logic              live_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (en) begin
            hd_d.data  = live_data;
            hd_d.valid = live_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign out_data  = en ? live_data  : hd_q.data;
    assign out_valid = en ? live_valid : hd_q.valid;
endmodule

// File: rtl/dly_line_ram.sv
module dly_line_ram #(
    parameter int DATA_W = dly_pkg::DEF_DATA_W,
    parameter int ADDR_W = dly_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] delay,
    output logic [DATA_W-1:0] dout,
    output logic              out_valid
);
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] delay_q;
    logic [ADDR_W-1:0] fill;
    logic              fill_ok;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] live_data;
    logic              live_valid;
    logic              bypass;

    dly_ptr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .delay_in (delay),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .rd_addr  (rd_addr),
        .delay_q  (delay_q),
        .fill     (fill),
        .fill_ok  (fill_ok)
    );

    dly_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
        .clk   (clk),
        .we    (en),
        .waddr (wr_ptr),
        .wdata (din),
        .raddr (rd_addr),
        .rdata (ram_rdata)
    );

    assign bypass     = (delay_q == '0);
    assign live_data  = bypass ? din : ram_rdata;
    assign live_valid = bypass | fill_ok;

    dly_out_hold #(.DATA_W(DATA_W)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .live_data  (live_data),
        .live_valid (live_valid),
        .out_data   (dout),
        .out_valid  (out_valid)
    );
endmodule

// File: rtl/dly_line_chk.sv
module dly_line_chk #(
    parameter int DATA_W = dly_pkg::DEF_DATA_W,
    parameter int ADDR_W = dly_pkg::DEF_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              out_valid,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] fill,
    input logic [ADDR_W-1:0] delay_q
);
    localparam logic [ADDR_W-1:0] TOP_IDX = '1;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)); // R2

    AST_PTR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(wr_ptr) && $stable(rd_ptr)); // R2

    AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr == ADDR_W'(wr_ptr + 1'b1)); // R8

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && delay_q == '0) |-> (out_valid && dout == din)); // R4

    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> ($stable(dout) && $stable(out_valid))); // R7

    AST_FILL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == TOP_IDX) |=> fill == TOP_IDX); // R6
endmodule

bind dly_line_ram dly_line_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .din       (din),
    .dout      (dout),
    .out_valid (out_valid),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .fill      (fill),
    .delay_q   (delay_q)
);

// File: tb/dly_line_ram_tb_top.sv
module dly_line_ram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] delay = '0;
    logic [DW-1:0] dout;
    logic          out_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    logic [DW-1:0] hist [64];
    int            nact = 0;
    int            mdelay = 0;
    logic [DW-1:0] hold_d = '0;
    bit            hold_v = 1'b0;
    bit            dly_changed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dly_line_ram #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .din(din),
        .delay(delay), .dout(dout), .out_valid(out_valid)
    );

    function automatic bit exp_valid(input int n, input int cnt);
        return (n == 0) || (cnt >= n);
    endfunction

    function automatic logic [DW-1:0] exp_data(input int n, input logic [DW-1:0] cur);
        if (n == 0) return cur;
        return hist[(nact - n) & 63];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act_d, input logic [DW-1:0] exp_d,
                         input bit act_v, input bit exp_v);
        checks++;
        if (act_v !== exp_v || (exp_v && act_d !== exp_d)) begin
            errors++;
            $display("FAIL %s: dout=%0h valid=%0b expected dout=%0h valid=%0b",
                     req, act_d, act_v, exp_d, exp_v);
        end
    endtask

    // one clock: drive after the edge, check mid-cycle, then update the model
    task automatic step(input bit e, input logic [DW-1:0] d, input int dl, input bit gap_end);
        logic [DW-1:0] ed;
        bit            ev;
        string         tag;
        @(posedge clk);
        #1;
        en = e; din = d; delay = AW'(dl);
        #3;
        if (e) begin
            ev = exp_valid(mdelay, nact);
            ed = exp_data(mdelay, d);
            if (gap_end)                     tag = "R2";
            else if (dly_changed)            tag = "R5";
            else if (mdelay == 0)            tag = "R4";
            else if (nact < mdelay)          tag = "R6";
            else if (nact > 64 && mdelay == 63) tag = "R8";
            else                             tag = "R3";
            check(tag, dout, ed, out_valid, ev);
            hold_d = ed; hold_v = ev;
            hist[nact & 63] = d;
            nact++;
        end else begin
            check("R7", dout, hold_d, out_valid, hold_v);
        end
        dly_changed = (dl != mdelay);
        mdelay = dl;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cur_dly;
        bit was_idle;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: after reset with enable low, output and flag read zero
        #3;
        check("R1", dout, '0, out_valid, 1'b0);
        step(1'b0, 8'h5A, 0, 1'b0);

        // R4: zero delay bypass
        for (int i = 0; i < 6; i++) step(1'b1, DW'($urandom), 0, 1'b0);

        // R5/R6/R3: move to delay 5, watch flag and data
        for (int i = 0; i < 20; i++) step(1'b1, DW'($urandom), 5, 1'b0);

        // R7 and R2: freeze, then resume
        for (int i = 0; i < 4; i++) step(1'b0, DW'($urandom), 5, 1'b0);
        step(1'b1, DW'($urandom), 5, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, DW'($urandom), 5, 1'b0);

        // R6: raise delay above fill count, R8: long run at 63
        for (int i = 0; i < 200; i++) step(1'b1, DW'($urandom), 63, 1'b0);

        // drop to delay 1 at once
        for (int i = 0; i < 10; i++) step(1'b1, DW'($urandom), 1, 1'b0);

        // random mix
        cur_dly = 1;
        was_idle = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            bit e;
            e = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 19) == 0) cur_dly = $urandom_range(0, 63);
            step(e, DW'($urandom), cur_dly, e && was_idle);
            was_idle = !e;
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule